// File: doc/BRIEF.md
# Ring Buffer Packet Fetch Sequencer

This block walks one command ring held in memory. Software programs the ring size, its base address, a starting read offset and an optional write-back address through a small register-write port. It then rings a doorbell by writing a new write offset. The sequencer works while the read offset differs from the write offset. For each packet it reads one 32-bit header dword at base plus read offset and looks at the opcode. Padding packets (opcode zero) carry their own count of extra dwords. The sequencer skips those dwords itself, one per cycle, and stops early if it reaches the write offset. Every other header is handed to a downstream executor. The executor later reports how many payload bytes the packet used, and the read offset moves past them.

Offsets are byte offsets that wrap at the ring size. The ring size is given as a log code: a control write with code `c` in bits 6:1 selects a ring of `1 << (c+2)` bytes. A code outside 6..62 is rejected and flagged. When the ring runs dry, the block can report its progress. If the write-back address is nonzero, it issues one memory write of the running, unwrapped read count and then goes idle.

States: `ST_IDLE` (waiting for a doorbell), `ST_CHECK` (compare offsets), `ST_REQ` (header read request), `ST_WAIT` (header return), `ST_SKIP` (padding skip), `ST_EXEC` (executor owns the packet), `ST_WBACK` (progress write). Transitions:
- IDLE→CHECK on a doorbell or a pending one.
- CHECK→REQ when the offsets differ.
- CHECK→WBACK when they are equal and the write-back address is nonzero.
- CHECK→IDLE otherwise.
- REQ→WAIT on request accept.
- WAIT→SKIP on a padding header, and WAIT→EXEC on any other header.
- SKIP→CHECK when the count is exhausted or the write offset is reached.
- EXEC→CHECK on executor done.
- WBACK→IDLE on write accept.

Top module: `ring_fetch_seq`

## Requirements
- R1: A control write (`reg_sel`=0) takes its size code from bits 6:1, and the ring is `1 << (code+2)` bytes; the code after reset is 6 (256 bytes). Read and write offsets wrap modulo the ring size.
- R2: A control write whose code is below 6 or above 62 sets `cfg_err` and leaves the ring size unchanged. A later legal control write clears `cfg_err`.
- R3: After a doorbell write (`reg_sel`=3), a header read is requested only while the read offset differs from the write offset. The request address is base (`reg_sel`=1) plus the read offset. At most one read is outstanding, and the address is held until `rd_req_ready`.
- R4: Header bits 7:0 are the opcode, and 0 means padding. For padding, bits 29:16 give the number of extra dwords to skip, so the next header is read at offset + 4 + 4·count.
- R5: If the read offset reaches the write offset while padding dwords remain, the rest of the count is dropped and `nop_warn` is set. `nop_warn` stays set until the next doorbell write.
- R6: A non-padding header is shown on `exe_header` with `exe_valid` held until `exe_done`. The next header is read at offset + 4 + `exe_bytes`.
- R7: When the offsets become equal, and only if the write-back address (`reg_sel`=4) is nonzero, one write of the unwrapped read count is issued on `wb_valid`/`wb_addr`/`wb_data`; `busy` then drops. The count is loaded by a read-offset write and grows by every byte consumed.
- R8: Control, base, read-offset (`reg_sel`=2) and write-back-address writes are ignored while `busy`. Doorbell writes are accepted at any time.
- R9: After reset, `busy`, `rd_req_valid`, `exe_valid`, `wb_valid`, `cfg_err` and `nop_warn` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | 0 control, 1 base, 2 read offset, 3 doorbell/write offset, 4 write-back address |
| reg_wdata | input | AW | Register write data |
| rd_req_valid | output | 1 | Header read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Header dword address |
| rd_rsp_valid | input | 1 | Read data strobe |
| rd_rsp_data | input | 32 | Header dword |
| exe_valid | output | 1 | Packet handed to executor |
| exe_header | output | 32 | Header of handed packet |
| exe_done | input | 1 | Executor finished packet |
| exe_bytes | input | EXW | Payload bytes consumed after the header |
| wb_valid | output | 1 | Read-count write-back request |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | AW | Write-back address |
| wb_data | output | PW | Unwrapped read count |
| busy | output | 1 | Ring being processed |
| cfg_err | output | 1 | Illegal size code seen |
| nop_warn | output | 1 | Padding skip clipped at write offset |

## Verification
A corrupted read offset or lost wrap mask shows at the ports on the very next header request as a wrong `rd_req_addr`, so the bench matches every accepted request against an expected address in order. A miscounted padding skip or executor advance shifts every later address. A wrong running count shows only at drain, in `wb_data`. A state machine that stalls or forgets a doorbell shows as `busy` never dropping, or as a missing or extra request, within tens of cycles.

// File: rtl/ring_fetch_pkg.sv
package ring_fetch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_REQ,
        ST_WAIT,
        ST_SKIP,
        ST_EXEC,
        ST_WBACK
    } rf_state_e;

    localparam logic [2:0] SEL_CTRL   = 3'd0;
    localparam logic [2:0] SEL_BASE   = 3'd1;
    localparam logic [2:0] SEL_RPTR   = 3'd2;
    localparam logic [2:0] SEL_WPTR   = 3'd3;
    localparam logic [2:0] SEL_WBADDR = 3'd4;

    localparam logic [7:0] OPC_PAD     = 8'h00;
    localparam logic [5:0] SZ_CODE_MIN = 6'd6;
    localparam logic [5:0] SZ_CODE_MAX = 6'd62;
    localparam int         SKIP_W      = 14;
    localparam int         DW_BYTES    = 4;

endpackage

// File: rtl/ring_size_decode.sv
module ring_size_decode
    import ring_fetch_pkg::*;
#(
    parameter int PW = 32
) (
    input  logic [5:0]    code,
    output logic          legal,
    output logic [PW-1:0] mask
);
    logic [6:0] expo;

    always_comb begin
        legal = (code >= SZ_CODE_MIN) && (code <= SZ_CODE_MAX);
        expo  = {1'b0, code} + 7'd2;
        for (int i = 0; i < PW; i++) begin
            mask[i] = (i < int'(expo));
        end
    end
endmodule

// File: rtl/ring_ptr_step.sv
module ring_ptr_step #(
    parameter int PW = 32
) (
    input  logic [PW-1:0] ptr,
    input  logic [PW-1:0] inc,
    input  logic [PW-1:0] mask,
    output logic [PW-1:0] nxt
);
    always_comb nxt = (ptr + inc) & mask;
endmodule

// File: rtl/ring_cfg_regs.sv
module ring_cfg_regs
    import ring_fetch_pkg::*;
#(
    parameter int AW = 40,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          wr_ctrl,
    input  logic          wr_base,
    input  logic          wr_wb,
    input  logic [AW-1:0] wdata,
    output logic [PW-1:0] mask,
    output logic [AW-1:0] base,
    output logic [AW-1:0] wb_addr,
    output logic          cfg_err
);
    localparam int RST_EXP = 8;

    logic          new_legal;
    logic [PW-1:0] new_mask;

    ring_size_decode #(.PW(PW)) u_dec (
        .code  (wdata[6:1]),
        .legal (new_legal),
        .mask  (new_mask)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask    <= {{(PW-RST_EXP){1'b0}}, {RST_EXP{1'b1}}};
            base    <= '0;
            wb_addr <= '0;
            cfg_err <= 1'b0;
        end else if (!busy) begin
            if (wr_ctrl) begin
                if (new_legal) begin
                    mask    <= new_mask;
                    cfg_err <= 1'b0;
                end else begin
                    cfg_err <= 1'b1;
                end
            end
            if (wr_base) base    <= wdata;
            if (wr_wb)   wb_addr <= wdata;
        end
    end

    assert_cfg_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !busy && !new_legal) |=> cfg_err);

    assert_size_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !new_legal) |=> $stable(mask));

    assert_base_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_base) |=> $stable(base));

    assert_wb_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_wb) |=> $stable(wb_addr));
endmodule

// File: rtl/ring_fetch_fsm.sv
module ring_fetch_fsm
    import ring_fetch_pkg::*;
#(
    parameter int AW  = 40,
    parameter int PW  = 32,
    parameter int EXW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           doorbell,
    input  logic [PW-1:0]  wptr_in,
    input  logic           rptr_load,
    input  logic [PW-1:0]  rptr_in,
    input  logic [PW-1:0]  mask,
    input  logic [AW-1:0]  base,
    input  logic [AW-1:0]  wb_addr,
    output logic           rd_req_valid,
    input  logic           rd_req_ready,
    output logic [AW-1:0]  rd_req_addr,
    input  logic           rd_rsp_valid,
    input  logic [31:0]    rd_rsp_data,
    output logic           exe_valid,
    output logic [31:0]    exe_header,
    input  logic           exe_done,
    input  logic [EXW-1:0] exe_bytes,
    output logic           wb_valid,
    input  logic           wb_ready,
    output logic [PW-1:0]  wb_data,
    output logic           busy,
    output logic           nop_warn
);
    rf_state_e         state_q, state_d;
    logic [PW-1:0]     rptr_q, wptr_q, glb_q;
    logic [SKIP_W-1:0] skip_q;
    logic [31:0]       hdr_q;
    logic              kick_q;
    logic [PW-1:0]     step_inc, rptr_adv;
    logic              ptr_eq, skip_left;

    assign ptr_eq    = (rptr_q == wptr_q);
    assign skip_left = (skip_q != '0);

    always_comb begin
        if (state_q == ST_EXEC) step_inc = {{(PW-EXW){1'b0}}, exe_bytes};
        else                    step_inc = PW'(DW_BYTES);
    end

    ring_ptr_step #(.PW(PW)) u_step (
        .ptr  (rptr_q),
        .inc  (step_inc),
        .mask (mask),
        .nxt  (rptr_adv)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (doorbell || kick_q) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!ptr_eq)             state_d = ST_REQ;
                else if (wb_addr != '0)  state_d = ST_WBACK;
                else                     state_d = ST_IDLE;
            end
            ST_REQ:   if (rd_req_ready) state_d = ST_WAIT;
            ST_WAIT: begin
                if (rd_rsp_valid)
                    state_d = (rd_rsp_data[7:0] == OPC_PAD) ? ST_SKIP : ST_EXEC;
            end
            ST_SKIP:  if (!skip_left || ptr_eq) state_d = ST_CHECK;
            ST_EXEC:  if (exe_done) state_d = ST_CHECK;
            ST_WBACK: if (wb_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // offsets, counters and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr_q   <= '0;
            wptr_q   <= '0;
            glb_q    <= '0;
            skip_q   <= '0;
            hdr_q    <= '0;
            kick_q   <= 1'b0;
            nop_warn <= 1'b0;
        end else begin
            if (doorbell)                kick_q <= 1'b1;
            else if (state_q == ST_CHECK) kick_q <= 1'b0;

            if (doorbell) wptr_q <= wptr_in & mask;

            if (doorbell) nop_warn <= 1'b0;

            unique case (state_q)
                ST_IDLE: begin
                    if (rptr_load) begin
                        rptr_q <= rptr_in & mask;
                        glb_q  <= rptr_in;
                    end
                end
                ST_WAIT: begin
                    if (rd_rsp_valid) begin
                        rptr_q <= rptr_adv;
                        glb_q  <= glb_q + PW'(DW_BYTES);
                        skip_q <= rd_rsp_data[16 +: SKIP_W];
                        hdr_q  <= rd_rsp_data;
                    end
                end
                ST_SKIP: begin
                    if (skip_left && !ptr_eq) begin
                        rptr_q <= rptr_adv;
                        glb_q  <= glb_q + PW'(DW_BYTES);
                        skip_q <= skip_q - 1'b1;
                    end else if (skip_left) begin
                        nop_warn <= 1'b1;
                        skip_q   <= '0;
                    end
                end
                ST_EXEC: begin
                    if (exe_done) begin
                        rptr_q <= rptr_adv;
                        glb_q  <= glb_q + step_inc;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy         = (state_q != ST_IDLE);
        rd_req_valid = (state_q == ST_REQ);
        exe_valid    = (state_q == ST_EXEC);
        wb_valid     = (state_q == ST_WBACK);
        rd_req_addr  = base + {{(AW-PW){1'b0}}, rptr_q};
        exe_header   = hdr_q;
        wb_data      = glb_q;
    end

    // single-outstanding tracker for the checks below
    logic outst_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           outst_q <= 1'b0;
        else if (rd_req_valid && rd_req_ready) outst_q <= 1'b1;
        else if (rd_rsp_valid)                 outst_q <= 1'b0;
    end

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

    assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> !outst_q);

    assert_clip_warn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP && skip_left && ptr_eq) |=> nop_warn);

    assert_exe_not_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exe_valid |-> (exe_header[7:0] != OPC_PAD));

    assert_exe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_valid && !exe_done) |=> (exe_valid && $stable(exe_header)));

    assert_wb_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_addr != '0));

    assert_drain_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_ready) |=> !busy);

    assert_rptr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rptr_load && state_q != ST_WAIT && state_q != ST_SKIP && state_q != ST_EXEC)
            |=> $stable(rptr_q));
endmodule

// File: rtl/ring_fetch_seq.sv
module ring_fetch_seq
    import ring_fetch_pkg::*;
#(
    parameter int AW  = 40,
    parameter int PW  = 32,
    parameter int EXW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [2:0]     reg_sel,
    input  logic [AW-1:0]  reg_wdata,
    output logic           rd_req_valid,
    input  logic           rd_req_ready,
    output logic [AW-1:0]  rd_req_addr,
    input  logic           rd_rsp_valid,
    input  logic [31:0]    rd_rsp_data,
    output logic           exe_valid,
    output logic [31:0]    exe_header,
    input  logic           exe_done,
    input  logic [EXW-1:0] exe_bytes,
    output logic           wb_valid,
    input  logic           wb_ready,
    output logic [AW-1:0]  wb_addr,
    output logic [PW-1:0]  wb_data,
    output logic           busy,
    output logic           cfg_err,
    output logic           nop_warn
);
    logic          wr_ctrl, wr_base, wr_rptr, wr_wptr, wr_wb;
    logic [PW-1:0] mask;
    logic [AW-1:0] base;

    assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
    assign wr_base = reg_wr && (reg_sel == SEL_BASE);
    assign wr_rptr = reg_wr && (reg_sel == SEL_RPTR);
    assign wr_wptr = reg_wr && (reg_sel == SEL_WPTR);
    assign wr_wb   = reg_wr && (reg_sel == SEL_WBADDR);

    ring_cfg_regs #(.AW(AW), .PW(PW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .wr_ctrl (wr_ctrl),
        .wr_base (wr_base),
        .wr_wb   (wr_wb),
        .wdata   (reg_wdata),
        .mask    (mask),
        .base    (base),
        .wb_addr (wb_addr),
        .cfg_err (cfg_err)
    );

    ring_fetch_fsm #(.AW(AW), .PW(PW), .EXW(EXW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .doorbell     (wr_wptr),
        .wptr_in      (reg_wdata[PW-1:0]),
        .rptr_load    (wr_rptr),
        .rptr_in      (reg_wdata[PW-1:0]),
        .mask         (mask),
        .base         (base),
        .wb_addr      (wb_addr),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_req_addr  (rd_req_addr),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data),
        .exe_valid    (exe_valid),
        .exe_header   (exe_header),
        .exe_done     (exe_done),
        .exe_bytes    (exe_bytes),
        .wb_valid     (wb_valid),
        .wb_ready     (wb_ready),
        .wb_data      (wb_data),
        .busy         (busy),
        .nop_warn     (nop_warn)
    );

    assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_req_valid && !exe_valid && !wb_valid));
endmodule

// File: tb/ring_fetch_seq_test.sv
module ring_fetch_seq_test;
    localparam int AW  = 40;
    localparam int PW  = 32;
    localparam int EXW = 16;
    localparam logic [AW-1:0] BASE = 40'h1000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [2:0]     reg_sel = '0;
    logic [AW-1:0]  reg_wdata = '0;
    logic           rd_req_valid, rd_req_ready = 1'b0;
    logic [AW-1:0]  rd_req_addr;
    logic           rd_rsp_valid = 1'b0;
    logic [31:0]    rd_rsp_data = '0;
    logic           exe_valid, exe_done = 1'b0;
    logic [31:0]    exe_header;
    logic [EXW-1:0] exe_bytes = '0;
    logic           wb_valid, wb_ready = 1'b0;
    logic [AW-1:0]  wb_addr;
    logic [PW-1:0]  wb_data;
    logic           busy, cfg_err, nop_warn;

    int checks = 0;
    int fails  = 0;
    int exe_stall = 2;
    int exe_cnt = 0;
    int cyc = 0;

    logic [31:0]   mem [logic [AW-1:0]];
    logic [AW-1:0] exp_fetch [$];
    string         exp_ftag  [$];
    logic [31:0]   exp_exe   [$];
    logic [AW-1:0] exp_wba   [$];
    logic [PW-1:0] exp_wbd   [$];

    always #2.5 clk = ~clk;

    ring_fetch_seq #(.AW(AW), .PW(PW), .EXW(EXW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .exe_valid(exe_valid), .exe_header(exe_header), .exe_done(exe_done), .exe_bytes(exe_bytes),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
        .busy(busy), .cfg_err(cfg_err), .nop_warn(nop_warn)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // environment models: memory, executor, write-back sink
    always @(posedge clk) begin
        cyc <= cyc + 1;
        rd_req_ready <= (cyc % 3) != 0;
        wb_ready     <= (cyc % 2) == 0;
        rd_rsp_valid <= 1'b0;
        if (rd_req_valid && rd_req_ready) begin
            rd_rsp_valid <= 1'b1;
            rd_rsp_data  <= mem.exists(rd_req_addr) ? mem[rd_req_addr] : 32'hDEAD0001;
        end
        if (exe_done) begin
            exe_done <= 1'b0;
        end else if (exe_valid) begin
            if (exe_cnt >= exe_stall) begin
                exe_done  <= 1'b1;
                exe_bytes <= EXW'(exe_header[23:16]) << 2;
                exe_cnt   <= 0;
            end else begin
                exe_cnt <= exe_cnt + 1;
            end
        end
    end

    // scoreboard monitors
    always @(negedge clk) begin
        if (rst_n && rd_req_valid && rd_req_ready) begin
            if (exp_fetch.size() == 0) begin
                chk(1'b0, "R3 unexpected fetch", 64'(rd_req_addr), 64'h0);
            end else begin
                logic [AW-1:0] e;
                string t;
                e = exp_fetch.pop_front();
                t = exp_ftag.pop_front();
                chk(rd_req_addr == e, t, 64'(rd_req_addr), 64'(e));
            end
        end
        if (rst_n && exe_valid && exe_done) begin
            if (exp_exe.size() == 0) begin
                chk(1'b0, "R6 unexpected packet", 64'(exe_header), 64'h0);
            end else begin
                logic [31:0] h;
                h = exp_exe.pop_front();
                chk(exe_header == h, "R6 executor header", 64'(exe_header), 64'(h));
            end
        end
        if (rst_n && wb_valid && wb_ready) begin
            if (exp_wba.size() == 0) begin
                chk(1'b0, "R7 unexpected write-back", 64'(wb_addr), 64'h0);
            end else begin
                logic [AW-1:0] a;
                logic [PW-1:0] d;
                a = exp_wba.pop_front();
                d = exp_wbd.pop_front();
                chk(wb_addr == a, "R7 write-back address", 64'(wb_addr), 64'(a));
                chk(wb_data == d, "R7 write-back count", 64'(wb_data), 64'(d));
            end
        end
    end

    task automatic reg_write(input logic [2:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic push_fetch(input logic [AW-1:0] a, input string tag);
        exp_fetch.push_back(a);
        exp_ftag.push_back(tag);
    endtask

    task automatic push_wb(input logic [AW-1:0] a, input logic [PW-1:0] d);
        exp_wba.push_back(a);
        exp_wbd.push_back(d);
    endtask

    task automatic wait_drain(input string tag);
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(exp_fetch.size() == 0, {tag, " missing fetch"}, 64'(exp_fetch.size()), 64'h0);
        chk(exp_exe.size() == 0, {tag, " missing packet"}, 64'(exp_exe.size()), 64'h0);
        chk(exp_wba.size() == 0, {tag, " missing write-back"}, 64'(exp_wba.size()), 64'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(!busy, "R9 busy", 64'(busy), 64'h0);
        chk(!rd_req_valid && !exe_valid && !wb_valid, "R9 requests",
            64'({rd_req_valid, exe_valid, wb_valid}), 64'h0);
        chk(!cfg_err && !nop_warn, "R9 flags", 64'({cfg_err, nop_warn}), 64'h0);

        // R2 size code legality
        reg_write(3'd0, 40'(63 << 1));
        chk(cfg_err, "R2 code 63 flagged", 64'(cfg_err), 64'h1);
        reg_write(3'd0, 40'(6 << 1));
        chk(!cfg_err, "R2 legal code clears", 64'(cfg_err), 64'h0);
        reg_write(3'd0, 40'(3 << 1));
        chk(cfg_err, "R2 code 3 flagged", 64'(cfg_err), 64'h1);

        // R3 R4 R6 R7 basic walk
        reg_write(3'd1, BASE);
        reg_write(3'd2, 40'h0);
        reg_write(3'd4, 40'h8000);
        mem[BASE + 0]  = 32'h0002_0001;
        mem[BASE + 12] = 32'h0002_0000;
        mem[BASE + 24] = 32'h0000_0002;
        push_fetch(BASE + 0,  "R3 first header");
        push_fetch(BASE + 12, "R6 after packet");
        push_fetch(BASE + 24, "R4 after padding");
        exp_exe.push_back(32'h0002_0001);
        exp_exe.push_back(32'h0000_0002);
        push_wb(40'h8000, 32'd28);
        reg_write(3'd3, 40'd28);
        wait_drain("R7 walk");
        chk(!nop_warn, "R4 no clip warning", 64'(nop_warn), 64'h0);

        // R5 clipped padding
        mem[BASE + 28] = 32'h000A_0000;
        push_fetch(BASE + 28, "R5 padding header");
        push_wb(40'h8000, 32'd36);
        reg_write(3'd3, 40'd36);
        wait_drain("R5 clip");
        chk(nop_warn, "R5 warning set", 64'(nop_warn), 64'h1);
        mem[BASE + 36] = 32'h0000_0003;
        push_fetch(BASE + 36, "R5 count dropped");
        exp_exe.push_back(32'h0000_0003);
        push_wb(40'h8000, 32'd40);
        reg_write(3'd3, 40'd40);
        chk(!nop_warn, "R5 doorbell clears warning", 64'(nop_warn), 64'h0);
        wait_drain("R5 resume");

        // R1 wrap at 256 bytes (illegal code 3 left size unchanged)
        reg_write(3'd2, 40'd248);
        mem[BASE + 248] = 32'h0000_0001;
        mem[BASE + 252] = 32'h0000_0000;
        mem[BASE + 0]   = 32'h0000_0004;
        push_fetch(BASE + 248, "R1 near end");
        push_fetch(BASE + 252, "R1 last dword");
        push_fetch(BASE + 0,   "R1 wrapped");
        exp_exe.push_back(32'h0000_0001);
        exp_exe.push_back(32'h0000_0004);
        push_wb(40'h8000, 32'd260);
        reg_write(3'd3, 40'd4);
        wait_drain("R1 wrap");
        reg_write(3'd0, 40'(6 << 1));
        chk(!cfg_err, "R2 cleared by legal write", 64'(cfg_err), 64'h0);

        // R7 no write-back with zero address
        reg_write(3'd4, 40'h0);
        reg_write(3'd2, 40'd4);
        mem[BASE + 4] = 32'h0000_0005;
        push_fetch(BASE + 4, "R7 zero address run");
        exp_exe.push_back(32'h0000_0005);
        reg_write(3'd3, 40'd8);
        wait_drain("R7 zero address");
        chk(!busy, "R7 busy dropped", 64'(busy), 64'h0);

        // R8 writes ignored while busy, doorbell accepted
        exe_stall = 20;
        mem[BASE + 8]  = 32'h0000_0006;
        mem[BASE + 12] = 32'h0000_0007;
        push_fetch(BASE + 8,  "R8 first");
        push_fetch(BASE + 12, "R8 base and offset kept");
        exp_exe.push_back(32'h0000_0006);
        exp_exe.push_back(32'h0000_0007);
        reg_write(3'd3, 40'd12);
        while (!exe_valid) @(negedge clk);
        reg_write(3'd2, 40'd100);
        reg_write(3'd1, 40'h5000);
        reg_write(3'd0, 40'(2 << 1));
        reg_write(3'd4, 40'h7000);
        reg_write(3'd3, 40'd16);
        chk(!cfg_err, "R8 control ignored", 64'(cfg_err), 64'h0);
        exe_stall = 2;
        wait_drain("R8 busy writes");

        // R3 no fetch when offsets equal; R7 count carried
        reg_write(3'd4, 40'h9000);
        push_wb(40'h9000, 32'd16);
        reg_write(3'd3, 40'd16);
        wait_drain("R3 equal offsets");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule